// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Controller

This block sits beside the transmit and receive FIFOs of a serial port and turns their fill levels and push/pop strobes into everything software and a DMA engine need to watch: a status word, five interrupt sources with a mask, one combined interrupt line, and one DMA request per direction. The FIFO storage and the shift engine live elsewhere. This block only observes the two levels, the strobes and a busy indication from the engine.

A small register file holds the programmable settings. These are a threshold for each FIFO, the interrupt mask, an enable bit for each DMA direction and a watermark for each direction. A write-only clear register acknowledges the sticky error sources. Reads go through a registered read port with one cycle of latency. The same port also returns the status word, the raw and masked sources and the two live FIFO levels. Every output of the block is registered and reflects the inputs of the previous clock cycle.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every programmable register reads 0, and `status`, `irq`, `tx_dreq`, `rx_dreq` and `rd_data` are 0.
- R2: One cycle after the inputs are sampled, `status` shows bit0 = busy, bit1 = transmit level equals DEPTH, bit2 = transmit level is 0, bit3 = receive level is 0, bit4 = receive level equals DEPTH.
- R3: Raw source bit0 is set while the transmit level is at or below the transmit threshold. Raw source bit4 is set while the receive level is at or above the receive threshold. Both follow the levels every cycle, and no write to the clear register changes them.
- R4: Raw source bit1 (transmit overflow) sets on a transmit push while the transmit level is DEPTH. Bit2 (receive underflow) sets on a receive pop while the receive level is 0. Bit3 (receive overflow) sets on a receive push while the receive level is DEPTH. Each stays set until cleared.
- R5: A write to the clear register (address 3) clears the following raw bits: data bit0 clears bits 1, 2 and 3; data bit1 clears bit2; data bit2 clears bit3; data bit3 clears bit1. A read of address 3 returns 0.
- R6: The masked status (address 9) is the raw sources (address 8) AND the mask (address 2). `irq` is high exactly when any masked bit is set.
- R7: `tx_dreq` is high when DMA-enable bit1 is set and the transmit level is at or below the transmit watermark. `rx_dreq` is high when DMA-enable bit0 is set and the receive level is above the receive watermark. Both are registered one cycle after the inputs.
- R8: Threshold and watermark registers keep only log2(DEPTH) bits. Writing DEPTH reads back 0, and writing DEPTH-1 reads back DEPTH-1.
- R9: `rd_data` returns, one cycle after `rd_addr`, the register at that address as it stood before the edge. The addresses are: 0 transmit threshold, 1 receive threshold, 2 mask, 4 DMA enable, 5 transmit watermark, 6 receive watermark, 7 status, 8 raw, 9 masked, 10 transmit level, 11 receive level. Any other address reads 0.
- R10: When an error event and a clear of the same sticky bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_in | input | 1 | Serial engine busy |
| tx_level | input | LVL_W | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LVL_W | Receive FIFO fill level, 0..DEPTH |
| tx_push | input | 1 | Transmit FIFO write strobe |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W | Registered read data |
| status | output | 5 | Status flags |
| irq | output | 1 | Combined masked interrupt |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
Random levels are drawn with a heavy bias toward 0, DEPTH and the programmed thresholds. This separates the at-or-below, at-or-above and strictly-above comparisons, which a plain uniform draw would rarely test. Random register writes, including clear-register writes with several bits set together, move the mask, thresholds and watermarks under the traffic. This shows whether the masking and the DMA gating use the current settings. Directed sequences cover the remaining cases. They push into a full FIFO and pop from an empty one, then clear each error with its own bit and with the clear-all bit. They also make an error event and its clear coincide, and write DEPTH into a threshold register.

// File: rtl/ifsc_pkg.sv
package ifsc_pkg;
  localparam int NSRC   = 5;
  localparam int NSTK   = 3;
  localparam int ADDR_W = 4;
  localparam int CLR_W  = 4;

  localparam logic [ADDR_W-1:0] A_TXTHR = 4'd0;
  localparam logic [ADDR_W-1:0] A_RXTHR = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
  localparam logic [ADDR_W-1:0] A_DMA   = 4'd4;
  localparam logic [ADDR_W-1:0] A_TXWM  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXWM  = 4'd6;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd8;
  localparam logic [ADDR_W-1:0] A_ISTAT = 4'd9;
  localparam logic [ADDR_W-1:0] A_TXLVL = 4'd10;
  localparam logic [ADDR_W-1:0] A_RXLVL = 4'd11;

  // raw source bit positions
  localparam int S_TXLOW  = 0;
  localparam int S_TXOVF  = 1;
  localparam int S_RXUNF  = 2;
  localparam int S_RXOVF  = 3;
  localparam int S_RXHIGH = 4;

  // status bit positions
  localparam int F_BUSY    = 0;
  localparam int F_TXFULL  = 1;
  localparam int F_TXEMPTY = 2;
  localparam int F_RXEMPTY = 3;
  localparam int F_RXFULL  = 4;

  // clear register bit positions
  localparam int C_ALL   = 0;
  localparam int C_RXUNF = 1;
  localparam int C_RXOVF = 2;
  localparam int C_TXOVF = 3;

  // sticky slot order inside the error bank
  localparam int K_TXOVF = 0;
  localparam int K_RXUNF = 1;
  localparam int K_RXOVF = 2;

  typedef struct packed {
    logic tx;   // data bit1
    logic rx;   // data bit0
  } dma_en_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ifsc_regs.sv
module ifsc_regs
  import ifsc_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  txthr,
  output logic [PTR_W-1:0]  rxthr,
  output logic [PTR_W-1:0]  txwm,
  output logic [PTR_W-1:0]  rxwm,
  output logic [NSRC-1:0]   mask,
  output dma_en_t           dma_en,
  output logic [CLR_W-1:0]  clr
);
  logic hit_clr;

  assign hit_clr = wr_en && (wr_addr == A_CLR);
  assign clr     = hit_clr ? wr_data[CLR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      txthr  <= '0;
      rxthr  <= '0;
      txwm   <= '0;
      rxwm   <= '0;
      mask   <= '0;
      dma_en <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_TXTHR: txthr  <= wr_data[PTR_W-1:0];
        A_RXTHR: rxthr  <= wr_data[PTR_W-1:0];
        A_TXWM:  txwm   <= wr_data[PTR_W-1:0];
        A_RXWM:  rxwm   <= wr_data[PTR_W-1:0];
        A_MASK:  mask   <= wr_data[NSRC-1:0];
        A_DMA:   dma_en <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  AST_THR_TRUNC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_TXTHR) |=> (txthr == $past(wr_data[PTR_W-1:0]))); // R8

  AST_CLR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CLR) |-> (clr == '0)); // R5
endmodule

// File: rtl/ifsc_sticky_bit.sv
module ifsc_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic nxt,
  output logic q
);
  // an event in the same cycle as a clear is kept
  assign nxt = set | (q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    set |=> q); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> (q == $past(q))); // R4

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && set) |=> q); // R10
endmodule

// File: rtl/ifsc_flags.sv
module ifsc_flags
  import ifsc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_in,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [PTR_W-1:0] txthr,
  input  logic [PTR_W-1:0] rxthr,
  input  logic [PTR_W-1:0] txwm,
  input  logic [PTR_W-1:0] rxwm,
  input  logic [NSRC-1:0]  mask,
  input  dma_en_t          dma_en,
  input  logic [NSTK-1:0]  stk_nxt,
  input  logic [NSTK-1:0]  stk_q,
  output logic [NSRC-1:0]  raw,
  output logic [NSRC-1:0]  status,
  output logic             irq,
  output logic             tx_dreq,
  output logic             rx_dreq
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic            tx_low_d, rx_high_d;
  logic            tx_low_q, rx_high_q;
  logic [NSRC-1:0] raw_d;

  assign tx_low_d  = tx_level <= LVL_W'(txthr);
  assign rx_high_d = rx_level >= LVL_W'(rxthr);

  always_comb begin
    raw_d           = '0;
    raw_d[S_TXLOW]  = tx_low_d;
    raw_d[S_TXOVF]  = stk_nxt[K_TXOVF];
    raw_d[S_RXUNF]  = stk_nxt[K_RXUNF];
    raw_d[S_RXOVF]  = stk_nxt[K_RXOVF];
    raw_d[S_RXHIGH] = rx_high_d;
  end

  always_comb begin
    raw           = '0;
    raw[S_TXLOW]  = tx_low_q;
    raw[S_TXOVF]  = stk_q[K_TXOVF];
    raw[S_RXUNF]  = stk_q[K_RXUNF];
    raw[S_RXOVF]  = stk_q[K_RXOVF];
    raw[S_RXHIGH] = rx_high_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_low_q  <= 1'b0;
      rx_high_q <= 1'b0;
      status    <= '0;
      irq       <= 1'b0;
      tx_dreq   <= 1'b0;
      rx_dreq   <= 1'b0;
    end else begin
      tx_low_q          <= tx_low_d;
      rx_high_q         <= rx_high_d;
      status[F_BUSY]    <= busy_in;
      status[F_TXFULL]  <= tx_level == FULL;
      status[F_TXEMPTY] <= tx_level == '0;
      status[F_RXEMPTY] <= rx_level == '0;
      status[F_RXFULL]  <= rx_level == FULL;
      irq               <= |(raw_d & mask);
      tx_dreq           <= dma_en.tx && (tx_level <= LVL_W'(txwm));
      rx_dreq           <= dma_en.rx && (rx_level >  LVL_W'(rxwm));
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(raw & $past(mask))); // R6

  AST_TXDREQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !dma_en.tx |=> !tx_dreq); // R7

  AST_RXDREQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !dma_en.rx |=> !rx_dreq); // R7

  AST_RXDREQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !rx_dreq); // R7
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import ifsc_pkg::*;
#(
  parameter  int DEPTH  = 16,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int DATA_W = imax(LVL_W, NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_in,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NSRC-1:0]   status,
  output logic              irq,
  output logic              tx_dreq,
  output logic              rx_dreq
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [PTR_W-1:0] txthr, rxthr, txwm, rxwm;
  logic [NSRC-1:0]  mask, raw;
  dma_en_t          dma_en;
  logic [CLR_W-1:0] clr;
  logic [NSTK-1:0]  stk_set, stk_clr, stk_nxt, stk_q;

  ifsc_regs #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .txthr(txthr), .rxthr(rxthr), .txwm(txwm), .rxwm(rxwm),
    .mask(mask), .dma_en(dma_en), .clr(clr)
  );

  // error events and the clear bits that address each sticky slot
  assign stk_set[K_TXOVF] = tx_push && (tx_level == FULL);
  assign stk_set[K_RXUNF] = rx_pop  && (rx_level == '0);
  assign stk_set[K_RXOVF] = rx_push && (rx_level == FULL);
  assign stk_clr[K_TXOVF] = clr[C_ALL] | clr[C_TXOVF];
  assign stk_clr[K_RXUNF] = clr[C_ALL] | clr[C_RXUNF];
  assign stk_clr[K_RXOVF] = clr[C_ALL] | clr[C_RXOVF];

  for (genvar k = 0; k < NSTK; k++) begin : g_stk
    ifsc_sticky_bit u_bit (
      .clk(clk), .rst(rst), .set(stk_set[k]), .clr(stk_clr[k]),
      .nxt(stk_nxt[k]), .q(stk_q[k])
    );
  end

  ifsc_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W), .PTR_W(PTR_W)) u_flags (
    .clk(clk), .rst(rst), .busy_in(busy_in),
    .tx_level(tx_level), .rx_level(rx_level),
    .txthr(txthr), .rxthr(rxthr), .txwm(txwm), .rxwm(rxwm),
    .mask(mask), .dma_en(dma_en), .stk_nxt(stk_nxt), .stk_q(stk_q),
    .raw(raw), .status(status), .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    case (rd_addr)
      A_TXTHR: rd_d = DATA_W'(txthr);
      A_RXTHR: rd_d = DATA_W'(rxthr);
      A_MASK:  rd_d = DATA_W'(mask);
      A_DMA:   rd_d = DATA_W'(dma_en);
      A_TXWM:  rd_d = DATA_W'(txwm);
      A_RXWM:  rd_d = DATA_W'(rxwm);
      A_STAT:  rd_d = DATA_W'(status);
      A_RAW:   rd_d = DATA_W'(raw);
      A_ISTAT: rd_d = DATA_W'(raw & mask);
      A_TXLVL: rd_d = DATA_W'(tx_level);
      A_RXLVL: rd_d = DATA_W'(rx_level);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CLR) |=> (rd_data == '0)); // R5

  AST_LEVEL_SRC_UNCLEARABLE: assert property (@(posedge clk) disable iff (rst)
    (clr[C_ALL] && tx_level == '0) |=> raw[S_TXLOW]); // R3
endmodule

// File: tb/sim_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_irq_ctrl;
  localparam int D  = 16;
  localparam int LW = $clog2(D + 1);
  localparam int PW = $clog2(D);
  localparam int DW = (LW > 5) ? LW : 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_in = 0, tx_push = 0, rx_push = 0, rx_pop = 0, wr_en = 0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [4:0] status;
  logic irq, tx_dreq, rx_dreq;

  always #5 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .busy_in(busy_in), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status), .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  int vectors = 0, fails = 0;
  string tag = "R9";

  // model state (register contents as held before the next edge)
  logic [PW-1:0] m_txthr, m_rxthr, m_txwm, m_rxwm;
  logic [4:0] m_mask, m_raw, m_stat;
  logic [1:0] m_dma;
  logic m_txo, m_rxu, m_rxo;

  task automatic chk(input string r, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_txthr = '0; m_rxthr = '0; m_txwm = '0; m_rxwm = '0;
    m_mask = '0; m_raw = '0; m_stat = '0; m_dma = '0;
    m_txo = 0; m_rxu = 0; m_rxo = 0;
  endtask

  // one clock: compute expectations from the current inputs, then sample after the edge
  task automatic cyc();
    logic [3:0] c;
    logic [4:0] raw, st;
    logic e_irq, e_tx, e_rx;
    logic [DW-1:0] e_rd;
    c = (wr_en && wr_addr == 4'd3) ? wr_data[3:0] : 4'd0;
    m_txo = (tx_push && tx_level == LW'(D)) | (m_txo & ~(c[0] | c[3]));
    m_rxu = (rx_pop && rx_level == '0)      | (m_rxu & ~(c[0] | c[1]));
    m_rxo = (rx_push && rx_level == LW'(D)) | (m_rxo & ~(c[0] | c[2]));
    raw = {rx_level >= LW'(m_rxthr), m_rxo, m_rxu, m_txo, tx_level <= LW'(m_txthr)};
    st = {rx_level == LW'(D), rx_level == '0, tx_level == '0, tx_level == LW'(D), busy_in};
    e_irq = |(raw & m_mask);
    e_tx = m_dma[1] && (tx_level <= LW'(m_txwm));
    e_rx = m_dma[0] && (rx_level > LW'(m_rxwm));
    case (rd_addr)
      4'd0: e_rd = DW'(m_txthr);
      4'd1: e_rd = DW'(m_rxthr);
      4'd2: e_rd = DW'(m_mask);
      4'd4: e_rd = DW'(m_dma);
      4'd5: e_rd = DW'(m_txwm);
      4'd6: e_rd = DW'(m_rxwm);
      4'd7: e_rd = DW'(m_stat);
      4'd8: e_rd = DW'(m_raw);
      4'd9: e_rd = DW'(m_raw & m_mask);
      4'd10: e_rd = DW'(tx_level);
      4'd11: e_rd = DW'(rx_level);
      default: e_rd = '0;
    endcase
    if (wr_en) begin
      case (wr_addr)
        4'd0: m_txthr = wr_data[PW-1:0];
        4'd1: m_rxthr = wr_data[PW-1:0];
        4'd2: m_mask  = wr_data[4:0];
        4'd4: m_dma   = wr_data[1:0];
        4'd5: m_txwm  = wr_data[PW-1:0];
        4'd6: m_rxwm  = wr_data[PW-1:0];
        default: ;
      endcase
    end
    m_raw = raw;
    m_stat = st;
    @(posedge clk); #1;
    chk("R2 status", int'(status), int'(st));
    chk("R6 irq", int'(irq), int'(e_irq));
    chk("R7 tx_dreq", int'(tx_dreq), int'(e_tx));
    chk("R7 rx_dreq", int'(rx_dreq), int'(e_rx));
    chk({tag, " rd_data"}, int'(rd_data), int'(e_rd));
  endtask

  task automatic idle();
    wr_en = 0; tx_push = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    wr_en = 1; wr_addr = a; wr_data = DW'(d); cyc(); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_addr = a; cyc(); cyc();
  endtask

  function automatic logic [LW-1:0] pick_level(input logic [PW-1:0] near);
    int s;
    s = $urandom_range(0, 5);
    case (s)
      0: return '0;
      1: return LW'(D);
      2: return LW'(near);
      3: return LW'(near) + 1'b1;
      default: return LW'($urandom_range(0, D));
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 tx_dreq", int'(tx_dreq), 0);
    chk("R1 rx_dreq", int'(rx_dreq), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst = 0;
    tag = "R1";
    for (int a = 0; a < 7; a++) begin
      rd_addr = 4'(a); cyc();
    end
    cyc();

    // R8: threshold truncation
    tag = "R8";
    wr(4'd0, D);     rd(4'd0);
    wr(4'd0, D - 1); rd(4'd0);
    wr(4'd5, D);     rd(4'd5);

    // R4 / R5: sticky errors and individual clears
    tag = "R4";
    wr(4'd2, 5'h1f);
    tx_level = LW'(D); tx_push = 1; cyc(); tx_push = 0;
    rx_level = '0; rx_pop = 1; cyc(); rx_pop = 0;
    rx_level = LW'(D); rx_push = 1; cyc(); rx_push = 0;
    tx_level = 4; rx_level = 3;
    rd(4'd8); rd(4'd9);
    tag = "R5";
    wr(4'd3, 4'b0010); rd(4'd8);
    wr(4'd3, 4'b0100); rd(4'd8);
    wr(4'd3, 4'b1000); rd(4'd8);
    rd(4'd3);
    // R3: clear-all leaves level sources untouched
    tag = "R3";
    wr(4'd1, 2); tx_level = 0; rx_level = 5;
    wr(4'd3, 4'b0001); rd(4'd8);
    // R10: event and clear in the same cycle
    tag = "R10";
    rx_level = '0; rx_pop = 1; wr(4'd3, 4'b0001); rx_pop = 0;
    rx_level = 5; rd(4'd8);
    wr(4'd3, 4'b0001); rd(4'd8);

    // R7: DMA requests around watermarks
    tag = "R7";
    wr(4'd4, 2'b11); wr(4'd5, 6); wr(4'd6, 6);
    for (int l = 5; l <= 7; l++) begin
      tx_level = LW'(l); rx_level = LW'(l); cyc();
    end
    wr(4'd4, 2'b00); cyc();

    // R6 / R9 / R2: constrained random traffic
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      busy_in  = 1'($urandom_range(0, 1));
      tx_level = pick_level(m_txthr);
      rx_level = pick_level(m_rxthr);
      tx_push  = ($urandom_range(0, 3) == 0);
      rx_push  = ($urandom_range(0, 3) == 0);
      rx_pop   = ($urandom_range(0, 3) == 0);
      wr_en    = ($urandom_range(0, 4) == 0);
      wr_addr  = 4'($urandom_range(0, 7));
      wr_data  = DW'($urandom);
      rd_addr  = 4'($urandom_range(0, 15));
      cyc();
    end
    idle();
    cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule